// File: doc/BRIEF.md
# Pixel Clock Programming Word Calculator

This block turns a requested pixel-clock period, given in picoseconds, into the 13-bit word and the post-divider setting that a serially programmed clock synthesizer needs. A host pulses `start` with the period on `period_ps`. The block then works through a short sequence. First it divides a fixed constant by the period to get the frequency in steps of 0.01 MHz. It rejects frequencies outside the synthesizer's usable band. It doubles an in-band frequency until it lands in the oscillator window and records how many times it doubled. It scales the result by the reference-divider ratio with rounding. Finally it packs the divider field, the post-divider code and two fixed stop bits into one word. Shifting the word out to the synthesizer is left to other logic.

All three divisions use one shared restoring divider that produces one quotient bit per cycle. A run therefore takes about a hundred cycles. When a run ends, `done` is high for one cycle. `prog_word`, `post_div` and `err` hold their values until the next run ends.

The controller has six states:
- `ST_IDLE` waits for `start`.
- `ST_DIV_FREQ` runs the frequency division.
- `ST_CHECK` tests the band.
- `ST_PRESCALE` doubles the frequency once per cycle.
- `ST_DIV_REF` runs the reference scaling.
- `ST_DIV_RND` runs the rounding division.

The transitions are:
- `ST_IDLE` to `ST_DIV_FREQ` on `start` with a non-zero period.
- `ST_IDLE` stays in `ST_IDLE` on `start` with a zero period, which raises an error.
- `ST_DIV_FREQ` to `ST_CHECK` when the quotient is ready.
- `ST_CHECK` to `ST_PRESCALE` when the frequency is in band.
- `ST_CHECK` to `ST_IDLE` when it is out of band, which raises an error.
- `ST_PRESCALE` to `ST_DIV_REF` once the frequency is at least 8000.
- `ST_DIV_REF` to `ST_DIV_RND` when the quotient is ready.
- `ST_DIV_RND` to `ST_IDLE` when the quotient is ready, which reports success.

Top module: `pclk_word_calc`

## Requirements
- R1: After reset, `prog_word`, `post_div`, `done` and `err` are all 0.
- R2: The frequency f is 100000000 / `period_ps`, with integer truncation. A period of 0 ends the run in the cycle after `start`, with `done` = 1, `err` = 1, and `prog_word` and `post_div` both 0.
- R3: If f is above 15938, the run ends with `err` = 1 and with `prog_word` and `post_div` both 0. A frequency of exactly 15938 is accepted.
- R4: If f is below 1000, the run ends with `err` = 1 and with `prog_word` and `post_div` both 0. A frequency of exactly 1000 is accepted.
- R5: The post-divider starts at 1. While f is below 8000, f is doubled and the post-divider is doubled. `post_div` reports the final value, which is 1, 2, 4 or 8.
- R6: Bits [8:0] of `prog_word` equal ((46000·f / 1432) + 500) / 1000 − 257, where f is the doubled frequency and each division is truncating.
- R7: Bits [10:9] of `prog_word` hold the post-divider code: 3 for a post-divider of 1, 2 for 2, 1 for 4 and 0 for 8.
- R8: On success, bits [12:11] of `prog_word` are both 1, and `err` is 0.
- R9: `done` is high for exactly one cycle per run. `prog_word`, `post_div` and `err` change only in the cycle where `done` is high.
- R10: A `start` that arrives while a run is in progress is ignored, and the run completes with the result for its own period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run; sampled only in idle |
| period_ps | input | 32 | Requested pixel period in picoseconds |
| prog_word | output | 13 | Packed synthesizer programming word |
| post_div | output | 4 | Post-divider chosen (1, 2, 4 or 8) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last run was rejected |

## Verification
The assertions assume that `start` and `period_ps` are never unknown while reset is released, and that reset is asserted from time zero. The bench meets both conditions: it drives every input to a known value before reset is released and changes inputs only on the falling clock edge. The assertions do not restrict the period value, so zero, tiny and huge periods are all legal and are all exercised. The bench sweeps the period across the whole band and past both ends. It also places extra points exactly on the band edges and on the post-divider thresholds.

// File: rtl/pclk_calc_pkg.sv
package pclk_calc_pkg;
    // numerator giving frequency in 0.01 MHz steps from picoseconds
    localparam int unsigned FREQ_NUM   = 100000000;
    localparam int unsigned F_MAX      = 15938;
    localparam int unsigned F_MIN      = 1000;
    localparam int unsigned VCO_LO     = 8000;
    // reference ratio 46/1432, pre-scaled by 1000 for rounding
    localparam int unsigned REF_MUL    = 46000;
    localparam int unsigned REF_DIV    = 1432;
    // rounding offset with the 257 adjustment folded in (500 - 257*1000 < 0)
    localparam int unsigned RND_ADD    = 500;
    localparam int unsigned RND_SUB    = 257000;
    localparam int unsigned RND_DIV    = 1000;

    localparam int LOW_W  = 9;
    localparam int CODE_W = 2;
    localparam int STOP_W = 2;
    localparam int WORD_W = LOW_W + CODE_W + STOP_W;
    localparam int PD_W   = 4;
    localparam int FW     = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIV_FREQ,
        ST_CHECK,
        ST_PRESCALE,
        ST_DIV_REF,
        ST_DIV_RND
    } calc_state_t;
endpackage

// File: rtl/pclk_seq_div.sv
module pclk_seq_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic         valid
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    shifted;
    logic [W:0]    trial;

    assign shifted = {rem_q, quotient[W-1]};
    assign trial   = shifted - {1'b0, den_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q    <= '0;
            den_q    <= '0;
            quotient <= '0;
            cnt_q    <= '0;
            valid    <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (go) begin
                rem_q    <= '0;
                den_q    <= divisor;
                quotient <= dividend;
                cnt_q    <= CW'(W);
            end else if (cnt_q != '0) begin
                if (!trial[W]) begin
                    rem_q    <= trial[W-1:0];
                    quotient <= {quotient[W-2:0], 1'b1};
                end else begin
                    rem_q    <= shifted[W-1:0];
                    quotient <= {quotient[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pclk_word_pack.sv
module pclk_word_pack
    import pclk_calc_pkg::*;
(
    input  logic [LOW_W-1:0]  low_field,
    input  logic [PD_W-1:0]   pdiv,
    output logic [WORD_W-1:0] word
);
    logic [CODE_W-1:0] code;

    always_comb begin
        unique case (pdiv)
            4'd1:    code = 2'd3;
            4'd2:    code = 2'd2;
            4'd4:    code = 2'd1;
            default: code = 2'd0;
        endcase
    end

    assign word = {{STOP_W{1'b1}}, code, low_field};
endmodule

// File: rtl/pclk_word_calc.sv
module pclk_word_calc
    import pclk_calc_pkg::*;
#(
    parameter int PERIOD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [PERIOD_W-1:0] period_ps,
    output logic [WORD_W-1:0]   prog_word,
    output logic [PD_W-1:0]     post_div,
    output logic                done,
    output logic                err
);
    localparam int DW = PERIOD_W;
    localparam logic [DW-1:0] C_NUM   = DW'(FREQ_NUM);
    localparam logic [DW-1:0] C_FMAX  = DW'(F_MAX);
    localparam logic [DW-1:0] C_FMIN  = DW'(F_MIN);
    localparam logic [DW-1:0] C_RMUL  = DW'(REF_MUL);
    localparam logic [DW-1:0] C_RDIV  = DW'(REF_DIV);
    localparam logic [DW-1:0] C_RADJ  = DW'(RND_ADD) - DW'(RND_SUB);
    localparam logic [DW-1:0] C_RNDD  = DW'(RND_DIV);
    localparam logic [FW-1:0] C_VCO   = FW'(VCO_LO);

    calc_state_t state, nxt;

    logic [FW-1:0]   freq_q;
    logic [PD_W-1:0] pd_q;
    logic            div_go;
    logic [DW-1:0]   div_a;
    logic [DW-1:0]   div_b;
    logic [DW-1:0]   div_q;
    logic            div_valid;
    logic            in_band;
    logic [WORD_W-1:0] packed_word;

    pclk_seq_div #(.W(DW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_a),
        .divisor  (div_b),
        .quotient (div_q),
        .valid    (div_valid)
    );

    pclk_word_pack u_pack (
        .low_field (div_q[LOW_W-1:0]),
        .pdiv      (pd_q),
        .word      (packed_word)
    );

    assign in_band = (div_q <= C_FMAX) && (div_q >= C_FMIN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and divider launch
    always_comb begin
        nxt    = state;
        div_go = 1'b0;
        div_a  = '0;
        div_b  = '0;
        unique case (state)
            ST_IDLE: begin
                if (start && period_ps != '0) begin
                    div_go = 1'b1;
                    div_a  = C_NUM;
                    div_b  = period_ps;
                    nxt    = ST_DIV_FREQ;
                end
            end
            ST_DIV_FREQ: if (div_valid) nxt = ST_CHECK;
            ST_CHECK:    nxt = in_band ? ST_PRESCALE : ST_IDLE;
            ST_PRESCALE: begin
                if (freq_q >= C_VCO) begin
                    div_go = 1'b1;
                    div_a  = C_RMUL * {{(DW-FW){1'b0}}, freq_q};
                    div_b  = C_RDIV;
                    nxt    = ST_DIV_REF;
                end
            end
            ST_DIV_REF: begin
                if (div_valid) begin
                    div_go = 1'b1;
                    div_a  = div_q + C_RADJ;
                    div_b  = C_RNDD;
                    nxt    = ST_DIV_RND;
                end
            end
            ST_DIV_RND: if (div_valid) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq_q    <= '0;
            pd_q      <= '0;
            prog_word <= '0;
            post_div  <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start && period_ps == '0) begin
                        prog_word <= '0;
                        post_div  <= '0;
                        err       <= 1'b1;
                        done      <= 1'b1;
                    end
                end
                ST_CHECK: begin
                    if (in_band) begin
                        freq_q <= div_q[FW-1:0];
                        pd_q   <= PD_W'(1);
                    end else begin
                        prog_word <= '0;
                        post_div  <= '0;
                        err       <= 1'b1;
                        done      <= 1'b1;
                    end
                end
                ST_PRESCALE: begin
                    if (freq_q < C_VCO) begin
                        freq_q <= freq_q << 1;
                        pd_q   <= pd_q << 1;
                    end
                end
                ST_DIV_RND: begin
                    if (div_valid) begin
                        prog_word <= packed_word;
                        post_div  <= pd_q;
                        err       <= 1'b0;
                        done      <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pclk_word_calc_chk.sv
module pclk_word_calc_chk
    import pclk_calc_pkg::*;
#(
    parameter int PERIOD_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [PERIOD_W-1:0] period_ps,
    input logic [WORD_W-1:0]   prog_word,
    input logic [PD_W-1:0]     post_div,
    input logic                done,
    input logic                err,
    input calc_state_t         st
);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(prog_word) && $stable(post_div) && $stable(err)));

    a_r3_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (prog_word == '0 && post_div == '0));

    a_r8_stop_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (prog_word[WORD_W-1 -: STOP_W] == {STOP_W{1'b1}}));

    a_r5_pd_power: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> ($countones(post_div) == 1 && post_div <= PD_W'(8)));

    a_r7_code_match: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (prog_word[LOW_W +: CODE_W] ==
            ((post_div == PD_W'(1)) ? 2'd3 :
             (post_div == PD_W'(2)) ? 2'd2 :
             (post_div == PD_W'(4)) ? 2'd1 : 2'd0)));

    a_r2_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start && period_ps == '0) |=> (done && err));

    a_r10_busy_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DIV_FREQ || st == ST_PRESCALE || st == ST_DIV_REF) |=> !done);
endmodule

bind pclk_word_calc pclk_word_calc_chk #(.PERIOD_W(PERIOD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .period_ps (period_ps),
    .prog_word (prog_word),
    .post_div  (post_div),
    .done      (done),
    .err       (err),
    .st        (state)
);

// File: tb/tb_pclk_word_calc.sv
module tb_pclk_word_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] period_ps = '0;
    logic [12:0] prog_word;
    logic [3:0]  post_div;
    logic        done;
    logic        err;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    pclk_word_calc dut (
        .clk(clk), .rst_n(rst_n), .start(start), .period_ps(period_ps),
        .prog_word(prog_word), .post_div(post_div), .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void model(input longint p, output bit e, output longint w, output longint pd);
        longint f, s, low, code;
        e = 1'b0; w = 0; pd = 0;
        if (p == 0) begin e = 1'b1; return; end
        f = 100000000 / p;
        if (f > 15938 || f < 1000) begin e = 1'b1; return; end
        pd = 1;
        while (f < 8000) begin f = f * 2; pd = pd * 2; end
        s = (46000 * f) / 1432;
        low = ((s + 500) / 1000) - 257;
        code = (pd == 1) ? 3 : (pd == 2) ? 2 : (pd == 4) ? 1 : 0;
        w = 'h1800 | (code << 9) | low;
    endfunction

    task automatic wait_done(output bit seen);
        int n = 0;
        while (!done && n < 400) begin @(negedge clk); n++; end
        seen = done;
    endtask

    task automatic check_result(input longint p, input string tag);
        bit e; longint w, pd;
        model(p, e, w, pd);
        check(err == e, (p == 0) ? "R2 err" : (e ? "R3 R4 err" : "R8 err"), err, e);
        if (e) begin
            check(prog_word == 0 && post_div == 0, "R3 R4 cleared outputs", prog_word, 0);
        end else begin
            check(post_div == pd, "R5 post_div", post_div, pd);
            check(prog_word[8:0] == w[8:0], "R6 low field", prog_word[8:0], w[8:0]);
            check(prog_word[10:9] == w[10:9], "R7 code", prog_word[10:9], w[10:9]);
            check(prog_word[12:11] == 2'b11, "R8 stop bits", prog_word[12:11], 3);
        end
        if (tag.len() != 0) check(1'b1, tag, 0, 0);
    endtask

    task automatic run(input longint p, input string tag);
        bit seen;
        @(negedge clk);
        start = 1'b1; period_ps = 32'(p);
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        check(seen, "R9 done seen", seen, 1);
        if (seen) begin
            check_result(p, tag);
            @(negedge clk);
            check(!done, "R9 done one cycle", done, 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit seen;
        logic [12:0] w0;
        repeat (3) @(negedge clk);
        // R1 reset values
        check(prog_word == 0 && post_div == 0 && done == 0 && err == 0, "R1 reset", prog_word, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 zero period: done in the cycle after start
        @(negedge clk);
        start = 1'b1; period_ps = 0;
        @(negedge clk);
        start = 1'b0;
        check(done && err, "R2 zero period immediate", {done, err}, 3);
        @(negedge clk);
        check(!done, "R9 done one cycle", done, 0);

        run(1, "R3 tiny period");
        run(6273, "R3 just above max");
        run(6274, "R3 max accepted");
        run(100000, "R4 min accepted");
        run(100001, "R4 just below min");
        run(64'hFFFF_FFFF, "R4 huge period");
        run(12500, "R5 f=8000 pd1");
        run(12501, "R5 f=7999 pd2");
        run(25000, "R5 pd2");
        run(25001, "R5 pd4");
        run(50000, "R5 pd4 edge");
        run(50001, "R5 pd8");

        // sweep across the band and past both ends
        for (longint p = 6000; p <= 101000; p += 131) run(p, "");

        // R9 hold: outputs unchanged while idle
        run(40000, "R6 mid");
        w0 = prog_word;
        repeat (10) @(negedge clk);
        check(prog_word == w0 && !done, "R9 hold", prog_word, w0);

        // R10 start during busy ignored
        @(negedge clk);
        start = 1'b1; period_ps = 30000;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        start = 1'b1; period_ps = 0;
        @(negedge clk);
        start = 1'b0;
        check(!done, "R10 no early done", done, 0);
        wait_done(seen);
        check(seen, "R10 done seen", seen, 1);
        if (seen) check_result(30000, "R10 own result");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule